// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block is the hazard controller of a five-stage in-order integer pipeline (fetch, decode, execute, memory, write-back). Each cycle it looks at the register indices and instruction-class flags held in the decode, execute, memory and write-back stages. From them it computes the bypass selects for the two execute operands, for the two inputs of the decode-stage branch comparator and for the memory-stage store data. It also produces the controls that freeze the PC and the decode register, squash the decode-to-execute register, and flush the fetched instruction when a branch is taken or the fetch slot is lost.

The unit is purely combinational: the datapath registers its outputs together with the pipeline registers they steer. Branches resolve in decode, so the comparator gets its own bypass path and its own stall rules. The register file is written in the first half-cycle and read in the second, so write-back values never need a bypass into decode. A mode input selects a unified instruction/data cache, in which a memory-stage access takes the fetch slot, or split caches, which never conflict.

Top module: `hazard_fwd_unit`

## Requirements
- R1: Each execute operand select (`fwd_ex_a` from `ex_rs1`/`ex_use_a`, `fwd_ex_b` from `ex_rs2`/`ex_use_b`) is 1 (take the EX/MEM result) when the memory stage holds a non-load that writes that register. Otherwise it is 2 (take the MEM/WB value) when the write-back stage writes it. Otherwise it is 0 (register file). An unused operand selects 0.
- R2: Register 0 never causes a bypass select other than 0 and never causes a stall.
- R3: `fwd_st_data` is 1 exactly when the memory stage holds a store whose data register `mem_rs2` is non-zero and is written by the write-back stage instruction.
- R4: When the execute stage holds a load writing a register that decode reads as an ALU operand or base address (`id_use_a`/`id_use_b`), `pc_hold`, `ifid_hold` and `idex_bubble` are all 1.
- R5: A decode-stage store whose data register (`id_rs2`, with `id_use_b` 0) matches a load in execute causes no stall.
- R6: Each branch comparator select (`fwd_br_a`, `fwd_br_b`) is 1 when the memory stage holds a non-load writing that branch source, and 0 otherwise. It is never 2.
- R7: A decode-stage branch stalls (all three hold/bubble outputs 1) when either source matches a register written by the execute-stage instruction, or one loaded by the memory-stage instruction.
- R8: A taken branch that is not stalled sets `redirect` and `ifid_flush` and clears `pc_hold`. A stalled branch never sets `redirect`.
- R9: With `unified_cache` 1, a memory-stage load or store, with no data stall and no redirect, sets `pc_hold` and `ifid_flush`. With `unified_cache` 0 it has no effect.
- R10: During a data stall, `ifid_flush` is 0.
- R11: With no matches and no memory access, all control outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| unified_cache | input | 1 | 1: instruction and data share one cache |
| id_rs1 | input | 5 | Decode source 1 index |
| id_rs2 | input | 5 | Decode source 2 index |
| id_use_a | input | 1 | Decode reads source 1 in execute (operand or base) |
| id_use_b | input | 1 | Decode reads source 2 as ALU operand |
| id_is_branch | input | 1 | Decode holds a conditional branch |
| id_br_taken | input | 1 | Branch comparator result, taken |
| ex_rs1 | input | 5 | Execute source 1 index |
| ex_rs2 | input | 5 | Execute source 2 index |
| ex_use_a | input | 1 | Execute reads source 1 |
| ex_use_b | input | 1 | Execute reads source 2 (operand or store data) |
| ex_rd | input | 5 | Execute destination index |
| ex_reg_wr | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_rs2 | input | 5 | Memory-stage store data register |
| mem_is_store | input | 1 | Memory stage holds a store |
| mem_rd | input | 5 | Memory-stage destination index |
| mem_reg_wr | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory stage holds a load |
| wb_rd | input | 5 | Write-back destination index |
| wb_reg_wr | input | 1 | Write-back instruction writes a register |
| fwd_ex_a | output | 2 | Execute operand A select |
| fwd_ex_b | output | 2 | Execute operand B select |
| fwd_br_a | output | 2 | Branch comparator A select |
| fwd_br_b | output | 2 | Branch comparator B select |
| fwd_st_data | output | 1 | Store data from MEM/WB |
| pc_hold | output | 1 | Keep the PC |
| ifid_hold | output | 1 | Keep the fetch/decode register |
| ifid_flush | output | 1 | Load a no-op into the fetch/decode register |
| idex_bubble | output | 1 | Load a no-op into the decode/execute register |
| redirect | output | 1 | Load the branch target into the PC |

## Verification
The bench targets the priority between two producers that write the same register. A design that prefers the older one would feed a stale value, which shows up as select 2 where 1 is due. It drives load-then-store pairs, where a stall taken on store data alone would show as a spurious hold. It also drives branches behind loads at both distances, where a missed memory-stage check would compare a value that does not exist yet. Register 0 as a destination, taken branches that coincide with a stall, and a memory access in each cache mode cover the remaining priority corners between stall, flush and redirect.

// File: rtl/hz_pkg.sv
package hz_pkg;
    localparam int REG_AW = 5;

    typedef enum logic [1:0] {
        FWD_RF    = 2'd0,
        FWD_EXMEM = 2'd1,
        FWD_MEMWB = 2'd2
    } fwd_sel_e;

    typedef struct packed {
        logic pc_hold;
        logic ifid_hold;
        logic ifid_flush;
        logic idex_bubble;
        logic redirect;
    } pipe_ctrl_t;
endpackage

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
    import hz_pkg::*;
#(
    parameter int AW = REG_AW
) (
    input  logic [AW-1:0] src,
    input  logic          use_src,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_alu_wr,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_wr,
    output fwd_sel_e      sel
);
    logic live;
    logic hit_mem;
    logic hit_wb;

    always_comb begin
        live    = use_src && (src != '0);
        hit_mem = live && mem_alu_wr && (mem_rd == src);
        hit_wb  = live && wb_wr && (wb_rd == src);
        if (hit_mem)
            sel = FWD_EXMEM;
        else if (hit_wb)
            sel = FWD_MEMWB;
        else
            sel = FWD_RF;
    end
endmodule

// File: rtl/hz_stall_detect.sv
module hz_stall_detect #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] id_rs1,
    input  logic [AW-1:0] id_rs2,
    input  logic          id_use_a,
    input  logic          id_use_b,
    input  logic          id_is_branch,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_reg_wr,
    input  logic          ex_is_load,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_reg_wr,
    input  logic          mem_is_load,
    output logic          load_use,
    output logic          br_stall
);
    logic ex_live;
    logic mem_ld_live;
    logic hit_ex_a;
    logic hit_ex_b;
    logic hit_mem_a;
    logic hit_mem_b;

    always_comb begin
        ex_live     = ex_reg_wr && (ex_rd != '0);
        mem_ld_live = mem_reg_wr && mem_is_load && (mem_rd != '0);
        hit_ex_a    = ex_live && (ex_rd == id_rs1);
        hit_ex_b    = ex_live && (ex_rd == id_rs2);
        hit_mem_a   = mem_ld_live && (mem_rd == id_rs1);
        hit_mem_b   = mem_ld_live && (mem_rd == id_rs2);
        load_use    = ex_is_load && ((id_use_a && hit_ex_a) || (id_use_b && hit_ex_b));
        br_stall    = id_is_branch && (hit_ex_a || hit_ex_b || hit_mem_a || hit_mem_b);
    end
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
    import hz_pkg::*;
#(
    parameter int AW = REG_AW
) (
    input  logic          unified_cache,
    input  logic [AW-1:0] id_rs1,
    input  logic [AW-1:0] id_rs2,
    input  logic          id_use_a,
    input  logic          id_use_b,
    input  logic          id_is_branch,
    input  logic          id_br_taken,
    input  logic [AW-1:0] ex_rs1,
    input  logic [AW-1:0] ex_rs2,
    input  logic          ex_use_a,
    input  logic          ex_use_b,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_reg_wr,
    input  logic          ex_is_load,
    input  logic [AW-1:0] mem_rs2,
    input  logic          mem_is_store,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_reg_wr,
    input  logic          mem_is_load,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_reg_wr,
    output logic [1:0]    fwd_ex_a,
    output logic [1:0]    fwd_ex_b,
    output logic [1:0]    fwd_br_a,
    output logic [1:0]    fwd_br_b,
    output logic          fwd_st_data,
    output logic          pc_hold,
    output logic          ifid_hold,
    output logic          ifid_flush,
    output logic          idex_bubble,
    output logic          redirect
);
    // Slots 0,1: execute operands; slots 2,3: decode branch comparator.
    localparam int NUM_SRC = 4;
    localparam int FIRST_BR = 2;

    logic [AW-1:0] src_v   [NUM_SRC];
    logic          use_v   [NUM_SRC];
    fwd_sel_e      sel_v   [NUM_SRC];
    logic          mem_alu_wr;
    logic          load_use;
    logic          br_stall;
    pipe_ctrl_t    ctrl_d;

    assign mem_alu_wr = mem_reg_wr && !mem_is_load;

    assign src_v[0] = ex_rs1;
    assign src_v[1] = ex_rs2;
    assign src_v[2] = id_rs1;
    assign src_v[3] = id_rs2;
    assign use_v[0] = ex_use_a;
    assign use_v[1] = ex_use_b;
    assign use_v[2] = id_is_branch;
    assign use_v[3] = id_is_branch;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_pick
        // Decode reads the register file after write-back has written it,
        // so the comparator slots never take the MEM/WB path.
        hz_fwd_pick #(.AW(AW)) u_pick (
            .src        (src_v[g]),
            .use_src    (use_v[g]),
            .mem_rd     (mem_rd),
            .mem_alu_wr (mem_alu_wr),
            .wb_rd      (wb_rd),
            .wb_wr      ((g < FIRST_BR) ? wb_reg_wr : 1'b0),
            .sel        (sel_v[g])
        );
    end

    hz_stall_detect #(.AW(AW)) u_stall (
        .id_rs1       (id_rs1),
        .id_rs2       (id_rs2),
        .id_use_a     (id_use_a),
        .id_use_b     (id_use_b),
        .id_is_branch (id_is_branch),
        .ex_rd        (ex_rd),
        .ex_reg_wr    (ex_reg_wr),
        .ex_is_load   (ex_is_load),
        .mem_rd       (mem_rd),
        .mem_reg_wr   (mem_reg_wr),
        .mem_is_load  (mem_is_load),
        .load_use     (load_use),
        .br_stall     (br_stall)
    );

    always_comb begin
        logic data_stall;
        logic port_busy;
        data_stall         = load_use || br_stall;
        port_busy          = unified_cache && (mem_is_load || mem_is_store);
        ctrl_d.redirect    = id_is_branch && id_br_taken && !data_stall;
        ctrl_d.ifid_hold   = data_stall;
        ctrl_d.idex_bubble = data_stall;
        ctrl_d.pc_hold     = data_stall || (port_busy && !ctrl_d.redirect);
        ctrl_d.ifid_flush  = !data_stall && (ctrl_d.redirect || port_busy);
    end

    assign fwd_ex_a    = sel_v[0];
    assign fwd_ex_b    = sel_v[1];
    assign fwd_br_a    = sel_v[2];
    assign fwd_br_b    = sel_v[3];
    assign fwd_st_data = mem_is_store && wb_reg_wr && (mem_rs2 != '0) && (wb_rd == mem_rs2);
    assign pc_hold     = ctrl_d.pc_hold;
    assign ifid_hold   = ctrl_d.ifid_hold;
    assign ifid_flush  = ctrl_d.ifid_flush;
    assign idex_bubble = ctrl_d.idex_bubble;
    assign redirect    = ctrl_d.redirect;
endmodule

// File: rtl/hazard_fwd_checker.sv
module hazard_fwd_checker #(
    parameter int AW = 5
) (
    input logic          unified_cache,
    input logic [AW-1:0] id_rs1,
    input logic [AW-1:0] id_rs2,
    input logic          id_use_a,
    input logic          id_use_b,
    input logic          id_is_branch,
    input logic          id_br_taken,
    input logic [AW-1:0] ex_rs1,
    input logic [AW-1:0] ex_rs2,
    input logic          ex_use_a,
    input logic          ex_use_b,
    input logic [AW-1:0] ex_rd,
    input logic          ex_reg_wr,
    input logic          ex_is_load,
    input logic [AW-1:0] mem_rs2,
    input logic          mem_is_store,
    input logic [AW-1:0] mem_rd,
    input logic          mem_reg_wr,
    input logic          mem_is_load,
    input logic [AW-1:0] wb_rd,
    input logic          wb_reg_wr,
    input logic [1:0]    fwd_ex_a,
    input logic [1:0]    fwd_ex_b,
    input logic [1:0]    fwd_br_a,
    input logic [1:0]    fwd_br_b,
    input logic          fwd_st_data,
    input logic          pc_hold,
    input logic          ifid_hold,
    input logic          ifid_flush,
    input logic          idex_bubble,
    input logic          redirect
);
    logic known;

    always_comb begin
        known = !$isunknown({unified_cache, id_rs1, id_rs2, id_use_a, id_use_b, id_is_branch,
                             id_br_taken, ex_rs1, ex_rs2, ex_use_a, ex_use_b, ex_rd, ex_reg_wr,
                             ex_is_load, mem_rs2, mem_is_store, mem_rd, mem_reg_wr, mem_is_load,
                             wb_rd, wb_reg_wr});
        if (known) begin
            AST_EX_SEL_LEGAL: assert (fwd_ex_a != 2'd3 && fwd_ex_b != 2'd3); // R1
            AST_ZERO_NO_BYPASS: assert (ex_rs1 != '0 || fwd_ex_a == 2'd0); // R2
            AST_ST_ZERO: assert (mem_rs2 != '0 || !fwd_st_data); // R3
            AST_STALL_TRIO: assert (pc_hold || !ifid_hold); // R4
            AST_BR_NO_WB: assert (fwd_br_a != 2'd2 && fwd_br_b != 2'd2); // R6
            AST_REDIRECT_FREE: assert (!(redirect && (ifid_hold || idex_bubble))); // R8
            AST_SPLIT_QUIET: assert (unified_cache || ifid_hold || redirect || !ifid_flush); // R9
            AST_FLUSH_VS_HOLD: assert (!(ifid_flush && ifid_hold)); // R10
        end
    end
endmodule

bind hazard_fwd_unit hazard_fwd_checker #(.AW(AW)) u_chk (.*);

// File: tb/hazard_fwd_unit_bench.sv
module hazard_fwd_unit_bench;
    localparam int AW = 5;
    localparam int NVEC = 20000;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic unified_cache, id_use_a, id_use_b, id_is_branch, id_br_taken;
    logic ex_use_a, ex_use_b, ex_reg_wr, ex_is_load;
    logic mem_is_store, mem_reg_wr, mem_is_load, wb_reg_wr;
    logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rs2, mem_rd, wb_rd;
    logic [1:0] fwd_ex_a, fwd_ex_b, fwd_br_a, fwd_br_b;
    logic fwd_st_data, pc_hold, ifid_hold, ifid_flush, idex_bubble, redirect;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;
    logic [31:0] rng = 32'h1ace_b00c;

    hazard_fwd_unit #(.AW(AW)) u_hazard_fwd_unit (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int m_ex(input logic [AW-1:0] s, input logic u);
        if (!u || s == 0) return 0;
        if (mem_reg_wr && !mem_is_load && mem_rd == s) return 1;
        if (wb_reg_wr && wb_rd == s) return 2;
        return 0;
    endfunction

    function automatic int m_br(input logic [AW-1:0] s);
        if (!id_is_branch || s == 0) return 0;
        return (mem_reg_wr && !mem_is_load && mem_rd == s) ? 1 : 0;
    endfunction

    task automatic check_all();
        bit lu, bs, ds, busy, rd;
        lu = ex_is_load && ex_reg_wr && ex_rd != 0 &&
             ((id_use_a && id_rs1 == ex_rd) || (id_use_b && id_rs2 == ex_rd));
        bs = id_is_branch && (
             (ex_reg_wr && ex_rd != 0 && (ex_rd == id_rs1 || ex_rd == id_rs2)) ||
             (mem_reg_wr && mem_is_load && mem_rd != 0 && (mem_rd == id_rs1 || mem_rd == id_rs2)));
        ds = lu || bs;
        busy = unified_cache && (mem_is_load || mem_is_store);
        rd = id_is_branch && id_br_taken && !ds;
        chk("R1 fwd_ex_a", fwd_ex_a, m_ex(ex_rs1, ex_use_a));
        chk("R1 fwd_ex_b", fwd_ex_b, m_ex(ex_rs2, ex_use_b));
        chk("R6 fwd_br_a", fwd_br_a, m_br(id_rs1));
        chk("R6 fwd_br_b", fwd_br_b, m_br(id_rs2));
        chk("R3 fwd_st_data", fwd_st_data,
            int'(mem_is_store && wb_reg_wr && mem_rs2 != 0 && wb_rd == mem_rs2));
        chk("R4/R7 ifid_hold", ifid_hold, int'(ds));
        chk("R4/R7 idex_bubble", idex_bubble, int'(ds));
        chk("R9 pc_hold", pc_hold, int'(ds || (busy && !rd)));
        chk("R8 redirect", redirect, int'(rd));
        chk("R10 ifid_flush", ifid_flush, int'(!ds && (rd || busy)));
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        return y ^ (y << 5);
    endfunction

    task automatic idle();
        {unified_cache, id_use_a, id_use_b, id_is_branch, id_br_taken} = '0;
        {ex_use_a, ex_use_b, ex_reg_wr, ex_is_load} = '0;
        {mem_is_store, mem_reg_wr, mem_is_load, wb_reg_wr} = '0;
        {id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rs2, mem_rd, wb_rd} = '0;
    endtask

    task automatic step();
        @(negedge clk);
        #2;
    endtask

    initial begin
        idle();
        step();
        // R11: idle pipeline
        chk("R11 all quiet", {fwd_ex_a, fwd_ex_b, fwd_br_a, fwd_br_b, fwd_st_data,
                              pc_hold, ifid_hold, ifid_flush, idex_bubble, redirect}, 0);

        // R1: both later stages write r3, youngest wins
        idle(); ex_rs1 = 3; ex_use_a = 1; mem_rd = 3; mem_reg_wr = 1; wb_rd = 3; wb_reg_wr = 1;
        step(); chk("R1 youngest producer", fwd_ex_a, 1);
        mem_is_load = 1; step(); chk("R1 load in MEM falls to WB", fwd_ex_a, 2);

        // R2: register 0 never bypasses or stalls
        idle(); ex_rs1 = 0; ex_use_a = 1; mem_rd = 0; mem_reg_wr = 1; wb_rd = 0; wb_reg_wr = 1;
        id_rs1 = 0; id_use_a = 1; ex_rd = 0; ex_reg_wr = 1; ex_is_load = 1;
        step(); chk("R2 zero bypass", fwd_ex_a, 0); chk("R2 zero stall", ifid_hold, 0);

        // R5: load then store using the loaded value only as data
        idle(); ex_rd = 4; ex_reg_wr = 1; ex_is_load = 1; id_rs2 = 4; id_rs1 = 6; id_use_a = 1;
        step(); chk("R5 store data no stall", pc_hold, 0);
        id_use_b = 1; step(); chk("R4 load-use stall", {pc_hold, ifid_hold, idex_bubble}, 7);

        // R3: store in MEM takes data from the load in WB
        idle(); mem_is_store = 1; mem_rs2 = 4; wb_rd = 4; wb_reg_wr = 1;
        step(); chk("R3 store data bypass", fwd_st_data, 1);

        // R7: branch behind a load, two then one cycle
        idle(); id_is_branch = 1; id_br_taken = 1; id_rs1 = 5; ex_rd = 5; ex_reg_wr = 1; ex_is_load = 1;
        step(); chk("R7 branch vs load in EX", ifid_hold, 1); chk("R8 no redirect in stall", redirect, 0);
        ex_reg_wr = 0; mem_rd = 5; mem_reg_wr = 1; mem_is_load = 1;
        step(); chk("R7 branch vs load in MEM", ifid_hold, 1);
        mem_is_load = 0; step();
        chk("R6 branch bypass", fwd_br_a, 1); chk("R8 redirect", redirect, 1);
        chk("R8 flush on taken", ifid_flush, 1);

        // R9: cache port conflict, both modes
        idle(); mem_is_load = 1; unified_cache = 1;
        step(); chk("R9 unified hold", {pc_hold, ifid_flush}, 3);
        unified_cache = 0; step(); chk("R9 split quiet", {pc_hold, ifid_flush}, 0);

        // Sweep: indices drawn from r0..r3 so matches are frequent
        for (int i = 0; i < NVEC; i++) begin
            logic [31:0] a, b;
            rng = nxt(rng); a = rng;
            rng = nxt(rng); b = rng;
            id_rs1 = AW'(a[1:0]);  id_rs2 = AW'(a[3:2]);  ex_rs1 = AW'(a[5:4]);
            ex_rs2 = AW'(a[7:6]);  ex_rd = AW'(a[9:8]);   mem_rs2 = AW'(a[11:10]);
            mem_rd = AW'(a[13:12]); wb_rd = AW'(a[15:14]);
            {unified_cache, id_use_a, id_use_b, id_is_branch, id_br_taken, ex_use_a, ex_use_b}
                = b[6:0];
            {ex_reg_wr, ex_is_load, mem_is_store, mem_reg_wr, mem_is_load, wb_reg_wr} = b[12:7];
            step();
            check_all();
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (NVEC + 1000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule